// File: doc/BRIEF.md
# Slave Port with Split Address and Data Stages

This block sits on the slave side of a shared bus and turns the bus's two-phase transfers into plain accesses to a local word memory. An address phase carries a word address, a read-not-write bit, a burst bit and eight byte-lane enables. A data-handshake phase moves one 64-bit word. The block holds this context in an address-stage register set. As soon as the data stage is free, it moves the context into a separate data-stage register set. A second master can therefore complete its address phase while an earlier data phase is still running, and the running transfer is not disturbed.

Single reads perform one local read per beat. A burst read fetches a block of consecutive words from memory on its first beat and serves later beats from that captured block. The block uses a beat counter that restarts at each new data stage. Writes store one word per beat. Each beat produces a response. The response is held with an availability flag until the requester takes it.

Top module: `stage_slave_port`

## Requirements
- R1: After reset, ap_ready is 1, and ap_ack, dh_ready and rsp_avail are 0. All memory words read back as zero.
- R2: When ap_valid is high while ap_ready is high, the context is captured at that clock edge. ap_ack is then high for exactly the next cycle, and ap_ready is low.
- R3: ap_ack_sec, valid together with ap_ack, is 1 if the data stage held a transfer at the capture edge, and 0 otherwise.
- R4: A captured context moves to the data stage on the following edge if the data stage is free, and dh_ready then rises. If the data stage is busy, the context waits (ap_ready stays low). The data stage's context does not change until that transfer ends.
- R5: A single write beat updates word ap_word_addr. Byte lane i (bits 8i+7..8i) takes the new data only when ap_be[i] is 1; the other lanes keep their old value.
- R6: A single read beat returns the memory word at the captured word address. A write beat returns rsp_data = 0.
- R7: In a burst read, beat k returns the word at index (base + k) mod MEM_WORDS. The block for up to BURST_WORDS beats is taken from memory on beat 0.
- R8: In a burst write, beat k writes the full word at (base + k) mod MEM_WORDS, and the byte enables are ignored.
- R9: After a beat, rsp_avail is 1 and rsp_data stays stable until a cycle with rsp_take high. dh_ready is 0 meanwhile, and dh_valid in that window has no effect.
- R10: A beat with dh_last high ends the data stage: dh_ready falls, and any waiting address context is moved in on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ap_valid | input | 1 | Address phase request |
| ap_word_addr | input | IW | Word address (IW = log2 MEM_WORDS) |
| ap_rnw | input | 1 | 1 = read, 0 = write |
| ap_burst | input | 1 | Burst transfer |
| ap_be | input | 8 | Byte-lane enables for single writes |
| ap_ready | output | 1 | Address stage free |
| ap_ack | output | 1 | Address phase accepted (one cycle) |
| ap_ack_sec | output | 1 | Accepted as secondary (data stage busy) |
| dh_valid | input | 1 | Data-handshake beat request |
| dh_wdata | input | 64 | Write data |
| dh_last | input | 1 | Last beat of the transfer |
| dh_ready | output | 1 | Beat can be accepted |
| rsp_avail | output | 1 | Response waiting |
| rsp_data | output | 64 | Response word |
| rsp_take | input | 1 | Consume the response |

## Verification
The hardest case to reach is an overlapping address phase. A second context must arrive while the data stage still holds an unfinished transfer, and the waiting context must be moved in exactly when the last beat is taken. The stimulus produces this case as follows. It opens a single read and lets it reach the data stage. It then issues a write address phase before sending any beat, and checks the secondary acknowledge and the stalled ap_ready. Next it completes the read and checks that the returned word belongs to the first address. Finally it runs the waiting write. A second hard case is a beat offered while a response is still pending during a burst. The bench offers that beat, and then shows through the following beats' data that the counter did not advance.

// File: rtl/ssp_pkg.sv
// Shared word/byte-lane types and the byte-enable expansion helper.
// Assumes 8-bit lanes; the data width is fixed at 64 bits.
package ssp_pkg;
    localparam int unsigned DATA_W = 64;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned BE_W   = DATA_W / LANE_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BE_W-1:0]   be_t;

    // Expand one enable bit per lane into a full bit mask.
    function automatic word_t lane_mask(input be_t be);
        word_t m;
        for (int i = 0; i < BE_W; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{be[i]}};
        end
        return m;
    endfunction
endpackage

// File: rtl/ssp_ctx_stages.sv
// Two-deep transfer context: an address-stage set filled by the address
// phase and a data-stage set that the beat engine works from.
// Assumes ds_release is only raised while ds_valid is high.
module ssp_ctx_stages
    import ssp_pkg::*;
#(
    parameter int unsigned IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ap_valid,
    input  logic [IW-1:0] ap_word_addr,
    input  logic          ap_rnw,
    input  logic          ap_burst,
    input  be_t           ap_be,
    output logic          ap_ready,
    output logic          ap_ack,
    output logic          ap_ack_sec,
    input  logic          ds_release,
    output logic          ds_load,
    output logic          ds_valid,
    output logic [IW-1:0] ds_idx,
    output logic          ds_rnw,
    output logic          ds_burst,
    output be_t           ds_be
);
    logic          as_valid;
    logic [IW-1:0] as_idx;
    logic          as_rnw;
    logic          as_burst;
    be_t           as_be;

    assign ap_ready = !as_valid;
    assign ds_load  = as_valid && !ds_valid;

    // Capture address phases, acknowledge them, and promote into the data stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            as_valid   <= 1'b0;
            as_idx     <= '0;
            as_rnw     <= 1'b0;
            as_burst   <= 1'b0;
            as_be      <= '0;
            ds_valid   <= 1'b0;
            ds_idx     <= '0;
            ds_rnw     <= 1'b0;
            ds_burst   <= 1'b0;
            ds_be      <= '0;
            ap_ack     <= 1'b0;
            ap_ack_sec <= 1'b0;
        end else begin
            ap_ack     <= 1'b0;
            ap_ack_sec <= 1'b0;
            if (ap_valid && !as_valid) begin
                as_valid   <= 1'b1;
                as_idx     <= ap_word_addr;
                as_rnw     <= ap_rnw;
                as_burst   <= ap_burst;
                as_be      <= ap_be;
                ap_ack     <= 1'b1;
                ap_ack_sec <= ds_valid;
            end
            if (ds_release) begin
                ds_valid <= 1'b0;
            end
            if (ds_load) begin
                ds_valid <= 1'b1;
                ds_idx   <= as_idx;
                ds_rnw   <= as_rnw;
                ds_burst <= as_burst;
                ds_be    <= as_be;
                as_valid <= 1'b0;
            end
        end
    end

    p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ap_ack |=> !ap_ack);
    p_busy_after_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_valid && ap_ready) |=> (ap_ack && !ap_ready));
    p_secondary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_valid && ap_ready && ds_valid) |=> ap_ack_sec);
    p_ds_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_valid && !ds_release) |=> (ds_valid && $stable(ds_idx) && $stable(ds_rnw)
                                       && $stable(ds_burst) && $stable(ds_be)));
endmodule

// File: rtl/ssp_local_mem.sv
// Local word memory: one lane-masked write port, one single-word read port
// and a block read port returning BLK consecutive words (index wraps).
// Assumes WORDS is a power of two; reset clears the contents.
module ssp_local_mem
    import ssp_pkg::*;
#(
    parameter int unsigned WORDS = 16,
    parameter int unsigned BLK   = 4,
    localparam int unsigned IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  word_t         wr_data,
    input  word_t         wr_mask,
    input  logic [IW-1:0] rd_idx,
    output word_t         rd_word,
    input  logic [IW-1:0] blk_base,
    output word_t         blk_words [BLK]
);
    word_t mem [WORDS];

    // Masked write of one word; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[w] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= (mem[wr_idx] & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    assign rd_word = mem[rd_idx];

    for (genvar k = 0; k < BLK; k++) begin : g_blk
        assign blk_words[k] = mem[blk_base + IW'(k)];
    end
endmodule

// File: rtl/ssp_beat_engine.sv
// Data-handshake engine: beat counter, burst block buffer, response
// register and availability flag. One response may be outstanding.
// Assumes ds_load only pulses while the data stage is empty.
module ssp_beat_engine
    import ssp_pkg::*;
#(
    parameter int unsigned IW  = 4,
    parameter int unsigned BLK = 4,
    localparam int unsigned BW = $clog2(BLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ds_load,
    input  logic          ds_valid,
    input  logic [IW-1:0] ds_idx,
    input  logic          ds_rnw,
    input  logic          ds_burst,
    input  be_t           ds_be,
    input  logic          dh_valid,
    input  word_t         dh_wdata,
    input  logic          dh_last,
    output logic          dh_ready,
    input  logic          rsp_take,
    output logic          rsp_avail,
    output word_t         rsp_data,
    output logic          ds_release,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output word_t         wr_data,
    output word_t         wr_mask,
    output logic [IW-1:0] rd_idx,
    input  word_t         rd_word,
    output logic [IW-1:0] blk_base,
    input  word_t         blk_words [BLK]
);
    logic [IW-1:0] cnt;
    logic [IW-1:0] cur_idx;
    logic          fire;
    word_t         blk_buf [BLK];

    assign dh_ready   = ds_valid && !rsp_avail;
    assign fire       = dh_valid && dh_ready;
    assign ds_release = fire && dh_last;
    assign cur_idx    = ds_idx + cnt;

    // Memory-side access for the current beat.
    always_comb begin
        wr_en    = fire && !ds_rnw;
        wr_idx   = cur_idx;
        wr_data  = dh_wdata;
        wr_mask  = ds_burst ? '1 : lane_mask(ds_be);
        rd_idx   = cur_idx;
        blk_base = ds_idx;
    end

    // Advance the beat, build the response and track its availability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            rsp_avail <= 1'b0;
            rsp_data  <= '0;
            for (int k = 0; k < BLK; k++) begin
                blk_buf[k] <= '0;
            end
        end else begin
            if (ds_load) begin
                cnt <= '0;
            end
            if (rsp_avail && rsp_take) begin
                rsp_avail <= 1'b0;
            end
            if (fire) begin
                rsp_avail <= 1'b1;
                cnt       <= cnt + 1'b1;
                if (!ds_rnw) begin
                    rsp_data <= '0;
                end else if (!ds_burst) begin
                    rsp_data <= rd_word;
                end else if (cnt == '0) begin
                    blk_buf  <= blk_words;
                    rsp_data <= blk_words[0];
                end else begin
                    rsp_data <= blk_buf[cnt[BW-1:0]];
                end
            end
        end
    end

    p_rsp_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_avail && !rsp_take) |=> (rsp_avail && $stable(rsp_data)));
    p_cnt_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_avail && !ds_load) |=> $stable(cnt));
    p_beat_sets_avail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dh_valid && dh_ready) |=> rsp_avail);
endmodule

// File: rtl/stage_slave_port.sv
// Slave-side port: address-phase capture with a separate data-stage copy,
// a beat engine and the local memory it serves.
// Assumes requesters hold each request for one cycle of acceptance.
module stage_slave_port
    import ssp_pkg::*;
#(
    parameter int unsigned MEM_WORDS   = 16,
    parameter int unsigned BURST_WORDS = 4,
    localparam int unsigned IW         = $clog2(MEM_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ap_valid,
    input  logic [IW-1:0] ap_word_addr,
    input  logic          ap_rnw,
    input  logic          ap_burst,
    input  logic [7:0]    ap_be,
    output logic          ap_ready,
    output logic          ap_ack,
    output logic          ap_ack_sec,
    input  logic          dh_valid,
    input  logic [63:0]   dh_wdata,
    input  logic          dh_last,
    output logic          dh_ready,
    output logic          rsp_avail,
    output logic [63:0]   rsp_data,
    input  logic          rsp_take
);
    logic          ds_load, ds_valid, ds_rnw, ds_burst, ds_release;
    logic [IW-1:0] ds_idx;
    be_t           ds_be;
    logic          wr_en;
    logic [IW-1:0] wr_idx, rd_idx, blk_base;
    word_t         wr_data, wr_mask, rd_word;
    word_t         blk_words [BURST_WORDS];

    ssp_ctx_stages #(.IW(IW)) u_stages (
        .clk(clk), .rst_n(rst_n),
        .ap_valid(ap_valid), .ap_word_addr(ap_word_addr), .ap_rnw(ap_rnw),
        .ap_burst(ap_burst), .ap_be(ap_be),
        .ap_ready(ap_ready), .ap_ack(ap_ack), .ap_ack_sec(ap_ack_sec),
        .ds_release(ds_release), .ds_load(ds_load), .ds_valid(ds_valid),
        .ds_idx(ds_idx), .ds_rnw(ds_rnw), .ds_burst(ds_burst), .ds_be(ds_be)
    );

    ssp_beat_engine #(.IW(IW), .BLK(BURST_WORDS)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .ds_load(ds_load), .ds_valid(ds_valid), .ds_idx(ds_idx),
        .ds_rnw(ds_rnw), .ds_burst(ds_burst), .ds_be(ds_be),
        .dh_valid(dh_valid), .dh_wdata(dh_wdata), .dh_last(dh_last),
        .dh_ready(dh_ready), .rsp_take(rsp_take), .rsp_avail(rsp_avail),
        .rsp_data(rsp_data), .ds_release(ds_release),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_mask(wr_mask),
        .rd_idx(rd_idx), .rd_word(rd_word), .blk_base(blk_base),
        .blk_words(blk_words)
    );

    ssp_local_mem #(.WORDS(MEM_WORDS), .BLK(BURST_WORDS)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_mask(wr_mask),
        .rd_idx(rd_idx), .rd_word(rd_word),
        .blk_base(blk_base), .blk_words(blk_words)
    );

    p_last_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dh_valid && dh_ready && dh_last) |=> (!ds_valid && !dh_ready));
    p_waiting_promoted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ap_ready && !ds_valid) |=> (ds_valid && ap_ready));
endmodule

// File: tb/stage_slave_port_tb_top.sv
`timescale 1ns/1ps
module stage_slave_port_tb_top;
    localparam int IW = 4;
    localparam logic [63:0] D0 = 64'h0101_0202_0303_0404;
    localparam logic [63:0] D1 = 64'h1111_1212_1313_1414;
    localparam logic [63:0] D2 = 64'h2121_2222_2323_2424;
    localparam logic [63:0] D3 = 64'h3131_3232_3333_3434;

    // Table of single transfers: op (1=read), word, enables, write data, expected response.
    localparam int NT = 7;
    localparam logic        T_RD  [NT] = '{0, 0, 0, 1, 1, 0, 1};
    localparam logic [3:0]  T_IDX [NT] = '{1, 2, 2, 1, 2, 1, 1};
    localparam logic [7:0]  T_BE  [NT] = '{8'hFF, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01, 8'h00};
    localparam logic [63:0] T_WD  [NT] = '{64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD,
                                          64'h5555_6666_7777_8888, 64'h0, 64'h0,
                                          64'hFFFF_FFFF_FFFF_FF99, 64'h0};
    localparam logic [63:0] T_EXP [NT] = '{64'h0, 64'h0, 64'h0, 64'h1111_2222_3333_4444,
                                          64'h5555_6666_CCCC_DDDD, 64'h0,
                                          64'h1111_2222_3333_4499};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ap_valid = 1'b0, ap_rnw = 1'b0, ap_burst = 1'b0;
    logic [IW-1:0] ap_word_addr = '0;
    logic [7:0] ap_be = '0;
    logic ap_ready, ap_ack, ap_ack_sec;
    logic dh_valid = 1'b0, dh_last = 1'b0, rsp_take = 1'b0;
    logic [63:0] dh_wdata = '0;
    logic dh_ready, rsp_avail;
    logic [63:0] rsp_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    stage_slave_port dut_i (
        .clk(clk), .rst_n(rst_n), .ap_valid(ap_valid), .ap_word_addr(ap_word_addr),
        .ap_rnw(ap_rnw), .ap_burst(ap_burst), .ap_be(ap_be), .ap_ready(ap_ready),
        .ap_ack(ap_ack), .ap_ack_sec(ap_ack_sec), .dh_valid(dh_valid),
        .dh_wdata(dh_wdata), .dh_last(dh_last), .dh_ready(dh_ready),
        .rsp_avail(rsp_avail), .rsp_data(rsp_data), .rsp_take(rsp_take)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue an address phase from a negedge; returns at the negedge after capture.
    task automatic addr_phase(input logic [IW-1:0] idx, input logic rd, input logic bst,
                              input logic [7:0] be, output logic sec);
        while (!ap_ready) @(negedge clk);
        ap_valid = 1'b1; ap_word_addr = idx; ap_rnw = rd; ap_burst = bst; ap_be = be;
        @(negedge clk);
        ap_valid = 1'b0;
        chk("R2 ack pulse", 64'(ap_ack), 64'd1);
        chk("R2 ready low after capture", 64'(ap_ready), 64'd0);
        sec = ap_ack_sec;
    endtask

    task automatic beat_hold(input logic [63:0] wd, input logic last, output logic [63:0] got);
        while (!dh_ready) @(negedge clk);
        dh_valid = 1'b1; dh_wdata = wd; dh_last = last;
        @(negedge clk);
        dh_valid = 1'b0; dh_last = 1'b0;
        chk("R9 response available", 64'(rsp_avail), 64'd1);
        got = rsp_data;
    endtask

    task automatic take;
        rsp_take = 1'b1;
        @(negedge clk);
        rsp_take = 1'b0;
    endtask

    task automatic beat(input logic [63:0] wd, input logic last, output logic [63:0] got);
        beat_hold(wd, last, got);
        take();
    endtask

    task automatic single(input logic rd, input logic [IW-1:0] idx, input logic [7:0] be,
                          input logic [63:0] wd, output logic [63:0] got);
        logic sec;
        addr_phase(idx, rd, 1'b0, be, sec);
        chk("R3 primary ack when data stage idle", 64'(sec), 64'd0);
        @(negedge clk);
        chk("R4 context promoted, dh_ready", 64'(dh_ready), 64'd1);
        beat(wd, 1'b1, got);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] got;
        logic sec;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ap_ready", 64'(ap_ready), 64'd1);
        chk("R1 ap_ack", 64'(ap_ack), 64'd0);
        chk("R1 dh_ready", 64'(dh_ready), 64'd0);
        chk("R1 rsp_avail", 64'(rsp_avail), 64'd0);
        single(1'b1, 4'd9, 8'h00, 64'h0, got);
        chk("R1 memory cleared", got, 64'h0);

        // Table walk: R5 lane writes, R6 reads and zero write response
        for (int i = 0; i < NT; i++) begin
            single(T_RD[i], T_IDX[i], T_BE[i], T_WD[i], got);
            chk(T_RD[i] ? "R6 single read / R5 lanes" : "R6 write response zero", got, T_EXP[i]);
        end

        // R8 burst write with wrap, enables ignored
        addr_phase(4'd14, 1'b0, 1'b1, 8'h00, sec);
        @(negedge clk);
        beat(D0, 1'b0, got);
        beat(D1, 1'b0, got);
        beat(D2, 1'b0, got);
        beat(D3, 1'b1, got);
        chk("R10 data stage ended", 64'(dh_ready), 64'd0);
        single(1'b1, 4'd0, 8'h00, 64'h0, got);
        chk("R8 wrapped word 0", got, D2);
        single(1'b1, 4'd15, 8'h00, 64'h0, got);
        chk("R8 word 15 full write", got, D1);

        // R7 burst read, with an ignored beat while the response is pending (R9)
        addr_phase(4'd14, 1'b1, 1'b1, 8'h00, sec);
        @(negedge clk);
        beat_hold(64'h0, 1'b0, got);
        chk("R7 burst beat 0", got, D0);
        @(negedge clk);
        @(negedge clk);
        chk("R9 flag held", 64'(rsp_avail), 64'd1);
        chk("R9 dh_ready low while pending", 64'(dh_ready), 64'd0);
        chk("R9 data held", rsp_data, D0);
        dh_valid = 1'b1; dh_last = 1'b1;
        @(negedge clk);
        dh_valid = 1'b0; dh_last = 1'b0;
        take();
        beat(64'h0, 1'b0, got);
        chk("R7 burst beat 1 (ignored beat left counter)", got, D1);
        beat(64'h0, 1'b0, got);
        chk("R7 burst beat 2 wraps", got, D2);
        beat(64'h0, 1'b1, got);
        chk("R7 burst beat 3", got, D3);

        // R3/R4/R10 overlapping address phase
        addr_phase(4'd14, 1'b1, 1'b0, 8'h00, sec);
        chk("R3 first is primary", 64'(sec), 64'd0);
        @(negedge clk);
        addr_phase(4'd3, 1'b0, 1'b0, 8'hFF, sec);
        chk("R3 overlap is secondary", 64'(sec), 64'd1);
        @(negedge clk);
        chk("R4 second context waits", 64'(ap_ready), 64'd0);
        beat(64'h0, 1'b1, got);
        chk("R4 in-flight read kept its address", got, D0);
        chk("R10 waiting context promoted", 64'(ap_ready), 64'd1);
        chk("R10 new data stage ready", 64'(dh_ready), 64'd1);
        beat(64'hCAFE_F00D_1234_5678, 1'b1, got);
        single(1'b1, 4'd3, 8'h00, 64'h0, got);
        chk("R4 secondary write landed", got, 64'hCAFE_F00D_1234_5678);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule